// File: doc/BRIEF.md
# Configurable SPI Controller with Internal Loopback

This block is a serial peripheral interface engine that can act as the clock-driving master or as a slave that follows an external clock. A single 16-bit mode word sets it up. The word selects a loopback path, the SCK idle level, the clock phase, an optional divide-by-16 stage, the bit order, the role, the enable, the character length and the prescale modulus. Characters are handed in on a valid/ready transmit port. Each received character leaves on a one-cycle receive pulse.

As master, the block starts a character when the transmit port offers a word. It drives SCK from a half-period generator that counts system-clock ticks, or every sixteenth tick when the divide stage is on. It holds its select output low for the whole character. As slave, it passes the external SCK and select through a synchronizer and shifts on the edges it sees. The system clock must run at least four times faster than SCK. In loopback the serial output is fed back to the receive shifter, and the serial input pin is ignored.

Mode writes made during a character reach the shift engine only at the next character boundary. Clearing the enable stops a character at once.

Top module: `spi_ctrl`

## Requirements
- R1: The mode register resets to 0 and reads back the last written word with bit 15 forced to 0. Field layout: bit 14 loopback, bit 13 SCK idle high, bit 12 early clock phase, bit 11 divide-by-16, bit 10 MSB first, bit 9 master, bit 8 enable, bits 7:4 length code, bits 3:0 prescale code.
- R2: With loopback set, each received character equals the transmitted character, whatever level ser_in has.
- R3: Whenever no character is in progress, sck_out rests at the level given by the idle-high bit (0 low, 1 high).
- R4: As master, every SCK half period lasts 2×(PM+1) system clocks, or 16×2×(PM+1) system clocks with divide-by-16 set. PM is the prescale code.
- R5: As master with the early phase bit set, the first SCK edge comes at the clock edge that accepts the transmit word. With the bit clear, it comes one half period later.
- R6: With MSB first set, ser_out presents the character from its top bit down. With the bit clear, it presents it from bit 0 up. Each bit is valid at the sampling edge.
- R7: A character has LEN+1 bits, where LEN is the length code. Codes 0 to 2 act as 3, which gives 4 bits. rx_word bits above the character are 0.
- R8: Mode writes made while a character is in progress do not change that character's timing or format. They apply from the next character on.
- R9: Clearing the enable during a character returns SCK to its idle level and raises sel_n_out within two clocks of the write, and no receive pulse follows.
- R10: As slave, the block shifts in ser_in and drives ser_out on edges of the synchronized sck_in while the synchronized sel_n_in is low. It uses the same phase and order rules as the master.
- R11: tx_ready is high only when the block is enabled, idle, and either master or seeing its select low. rx_valid is a one-cycle pulse per completed character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_we | input | 1 | Write strobe for the mode register |
| mode_wdata | input | 16 | Mode word to write |
| mode_rdata | output | 16 | Current mode register contents |
| tx_valid | input | 1 | Transmit word offered |
| tx_word | input | 16 | Transmit word, right aligned |
| tx_ready | output | 1 | Transmit word accepted when high with tx_valid |
| rx_valid | output | 1 | One-cycle pulse: rx_word holds a new character |
| rx_word | output | 16 | Received character, right aligned |
| sck_out | output | 1 | SCK driven in master role |
| sck_in | input | 1 | External SCK used in slave role |
| sel_n_out | output | 1 | Active-low select driven in master role |
| sel_n_in | input | 1 | Active-low select used in slave role |
| ser_out | output | 1 | Serial data out (MOSI as master, MISO as slave) |
| ser_in | input | 1 | Serial data in (MISO as master, MOSI as slave) |

## Verification
A step counter that drifts would show up as a wrong SCK half period or a character that ends early. It would also corrupt rx_word within one character. A wrong order or length selection shows as a misassembled rx_word at the first pulse, and loopback makes that visible without any external model. A broken deferral or abort path shows within a half period: SCK spacing changes mid-character, or an SCK edge or receive pulse appears after the enable is cleared.

// File: rtl/spi_ctrl_pkg.sv
package spi_ctrl_pkg;

    localparam int MAX_W = 16;
    localparam int CNT_W = $clog2(MAX_W);

    typedef struct packed {
        logic             rsvd;
        logic             lpbk;
        logic             ck_idle_hi;
        logic             ck_early;
        logic             pre16;
        logic             msb_first;
        logic             is_master;
        logic             on;
        logic [CNT_W-1:0] clen;
        logic [CNT_W-1:0] pdiv;
    } mode_t;

    typedef enum logic [1:0] {ST_IDLE, ST_MASTER, ST_SLAVE} state_t;

    function automatic logic [CNT_W-1:0] top_index(input logic [CNT_W-1:0] code);
        return (code < CNT_W'(3)) ? CNT_W'(3) : code;
    endfunction

    function automatic logic [MAX_W-1:0] keep_low(input logic [MAX_W-1:0] d,
                                                  input logic [CNT_W-1:0] top);
        logic [MAX_W-1:0] m;
        m = {MAX_W{1'b1}} >> (CNT_W'(MAX_W - 1) - top);
        return d & m;
    endfunction

endpackage

// File: rtl/spi_baud_gen.sv
module spi_baud_gen
    import spi_ctrl_pkg::*;
#(
    parameter int PRE_DIV = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             pre16,
    input  logic [CNT_W-1:0] pdiv,
    output logic             hp_tick
);
    localparam int PW = $clog2(PRE_DIV);

    logic [PW-1:0]    pre_cnt;
    logic             in_tick;
    logic [CNT_W:0]   hp_cnt;
    logic [CNT_W:0]   hp_lim;

    // selected input clock: every system clock or every PRE_DIV-th one
    assign in_tick = pre16 ? (pre_cnt == PW'(PRE_DIV - 1)) : 1'b1;
    // half period is 2*(pdiv+1) input ticks, so the terminal count is 2*pdiv+1
    assign hp_lim  = {pdiv, 1'b1};
    assign hp_tick = run && in_tick && (hp_cnt == hp_lim);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pre_cnt <= '0;
            hp_cnt  <= '0;
        end else begin
            pre_cnt <= (pre_cnt == PW'(PRE_DIV - 1)) ? '0 : pre_cnt + 1'b1;
            if (in_tick)
                hp_cnt <= hp_tick ? '0 : hp_cnt + 1'b1;
        end
    end

    AST_TICK_GAP: assert property (@(posedge clk) disable iff (rst)
        hp_tick |=> !hp_tick); // R4

endmodule

// File: rtl/spi_shifter.sv
module spi_shifter
    import spi_ctrl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [MAX_W-1:0] load_word,
    input  logic             shift,
    input  logic             sample,
    input  logic             din,
    input  logic             msb_first,
    input  logic [CNT_W-1:0] top,
    output logic             dout,
    output logic [MAX_W-1:0] rx_now
);
    logic [MAX_W-1:0] tx_sr;
    logic [MAX_W-1:0] rx_sr;

    assign dout = msb_first ? tx_sr[top] : tx_sr[0];

    // assembled character including the bit present on din this cycle
    always_comb begin
        if (msb_first)
            rx_now = keep_low({rx_sr[MAX_W-2:0], din}, top);
        else
            rx_now = keep_low((rx_sr >> 1) | (MAX_W'(din) << top), top);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_sr <= '0;
            rx_sr <= '0;
        end else if (load) begin
            tx_sr <= load_word;
            rx_sr <= '0;
        end else begin
            if (shift)
                tx_sr <= msb_first ? (tx_sr << 1) : (tx_sr >> 1);
            if (sample)
                rx_sr <= rx_now;
        end
    end

endmodule

// File: rtl/spi_ctrl.sv
module spi_ctrl
    import spi_ctrl_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int PRE_DIV     = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_we,
    input  logic [15:0]      mode_wdata,
    output logic [15:0]      mode_rdata,
    input  logic             tx_valid,
    input  logic [MAX_W-1:0] tx_word,
    output logic             tx_ready,
    output logic             rx_valid,
    output logic [MAX_W-1:0] rx_word,
    output logic             sck_out,
    input  logic             sck_in,
    output logic             sel_n_out,
    input  logic             sel_n_in,
    output logic             ser_out,
    input  logic             ser_in
);
    localparam int KW = CNT_W + 2;

    mode_t            pend, cur, eff;
    state_t           st;
    logic             busy;
    logic [CNT_W-1:0] top_bit;
    logic [SYNC_STAGES:0]   sck_p;
    logic [SYNC_STAGES-1:0] sel_p;
    logic             sck_s, sck_d, sel_s;
    logic [KW-1:0]    k, k_next, end_k;
    logic [CNT_W-1:0] nbit;
    logic             sck_raw;
    logic             hp_tick, dout, rx_din;
    logic [MAX_W-1:0] rx_now;
    logic             m_start, s_start, m_tick, m_sample, m_shift, m_toggle, m_done;
    logic             s_edge, s_lead, s_trail, s_sample, s_shift;
    logic             sample, shift, last_bit, abort;

    // pending register is software-visible; cur is frozen while a character runs
    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
            cur  <= '0;
        end else begin
            if (mode_we)
                pend <= mode_t'(mode_wdata & 16'h7FFF);
            if (!busy)
                cur <= pend;
        end
    end

    assign busy       = (st != ST_IDLE);
    assign eff        = busy ? cur : pend;
    assign mode_rdata = pend;
    assign top_bit    = top_index(eff.clen);

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_p <= '0;
            sel_p <= '1;
        end else begin
            sck_p <= {sck_p[SYNC_STAGES-1:0], sck_in};
            sel_p <= {sel_p[SYNC_STAGES-2:0], sel_n_in};
        end
    end
    assign sck_s = sck_p[SYNC_STAGES-1];
    assign sck_d = sck_p[SYNC_STAGES];
    assign sel_s = sel_p[SYNC_STAGES-1];

    spi_baud_gen #(.PRE_DIV(PRE_DIV)) u_baud (
        .clk(clk), .rst(rst), .run(st == ST_MASTER),
        .pre16(eff.pre16), .pdiv(eff.pdiv), .hp_tick(hp_tick)
    );

    // master: half-period steps 1..2N; odd steps sample, even steps shift
    assign tx_ready = (st == ST_IDLE) && pend.on && (pend.is_master || !sel_s);
    assign m_start  = (st == ST_IDLE) && pend.on && pend.is_master && tx_valid;
    assign s_start  = (st == ST_IDLE) && pend.on && !pend.is_master && !sel_s;
    assign k_next   = k + 1'b1;
    assign end_k    = KW'({top_bit, 1'b0}) + KW'(2);
    assign m_tick   = (st == ST_MASTER) && hp_tick;
    assign m_sample = m_tick && k_next[0];
    assign m_shift  = m_tick && !k_next[0] && (k_next != end_k);
    assign m_toggle = m_tick && (!eff.ck_early || (k_next != end_k));
    assign m_done   = m_tick && (k_next == end_k);

    // slave: edges of the synchronized clock
    assign s_edge   = (st == ST_SLAVE) && (sck_s != sck_d);
    assign s_lead   = s_edge && (sck_s != eff.ck_idle_hi);
    assign s_trail  = s_edge && !s_lead;
    assign s_sample = eff.ck_early ? s_trail : s_lead;
    assign s_shift  = (eff.ck_early ? s_lead : s_trail) && (nbit != '0);

    assign sample   = m_sample || s_sample;
    assign shift    = m_shift || s_shift;
    assign last_bit = sample && (nbit == top_bit);
    assign abort    = busy && (!pend.on || ((st == ST_SLAVE) && sel_s));

    assign ser_out   = busy ? dout : 1'b0;
    assign rx_din    = eff.lpbk ? ser_out : ser_in;
    assign sck_out   = eff.ck_idle_hi ^ sck_raw;
    assign sel_n_out = (st != ST_MASTER);

    spi_shifter u_shift (
        .clk(clk), .rst(rst), .load(m_start || s_start),
        .load_word((s_start && !tx_valid) ? '0 : tx_word),
        .shift(shift), .sample(sample), .din(rx_din),
        .msb_first(eff.msb_first), .top(top_bit),
        .dout(dout), .rx_now(rx_now)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            k        <= '0;
            nbit     <= '0;
            sck_raw  <= 1'b0;
            rx_valid <= 1'b0;
            rx_word  <= '0;
        end else begin
            rx_valid <= 1'b0;
            case (st)
                ST_IDLE: begin
                    k       <= '0;
                    nbit    <= '0;
                    sck_raw <= 1'b0;
                    if (m_start) begin
                        st      <= ST_MASTER;
                        sck_raw <= pend.ck_early;
                    end else if (s_start) begin
                        st <= ST_SLAVE;
                    end
                end
                ST_MASTER, ST_SLAVE: begin
                    if (abort) begin
                        st      <= ST_IDLE;
                        sck_raw <= 1'b0;
                    end else begin
                        if (m_tick)
                            k <= k_next;
                        if (m_toggle)
                            sck_raw <= ~sck_raw;
                        if (sample)
                            nbit <= nbit + 1'b1;
                        if (last_bit) begin
                            rx_valid <= 1'b1;
                            rx_word  <= rx_now;
                        end
                        if (m_done || ((st == ST_SLAVE) && last_bit)) begin
                            st      <= ST_IDLE;
                            sck_raw <= 1'b0;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    AST_MODE_READBACK: assert property (@(posedge clk) disable iff (rst)
        mode_we |=> (mode_rdata == ($past(mode_wdata) & 16'h7FFF))); // R1
    AST_IDLE_SCK: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE) |-> (sck_out == pend.ck_idle_hi)); // R3
    AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(cur)); // R8
    AST_DISABLE_STOP: assert property (@(posedge clk) disable iff (rst)
        (busy && !pend.on) |=> (st == ST_IDLE)); // R9
    AST_RX_PULSE: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid); // R11

endmodule

// File: tb/tb_spi_ctrl.sv
module tb_spi_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode_we = 1'b0;
    logic [15:0] mode_wdata = '0;
    logic [15:0] mode_rdata;
    logic        tx_valid = 1'b0;
    logic [15:0] tx_word = '0;
    logic        tx_ready, rx_valid;
    logic [15:0] rx_word;
    logic        sck_out, sel_n_out, ser_out;
    logic        sck_in = 1'b0;
    logic        sel_n_in = 1'b1;
    logic        ser_in = 1'b1;

    int n_cmp = 0;
    int n_bad = 0;
    logic [15:0] exp_q[$];

    always #2 clk = ~clk;

    spi_ctrl dut (
        .clk(clk), .rst(rst), .mode_we(mode_we), .mode_wdata(mode_wdata),
        .mode_rdata(mode_rdata), .tx_valid(tx_valid), .tx_word(tx_word),
        .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_word(rx_word),
        .sck_out(sck_out), .sck_in(sck_in), .sel_n_out(sel_n_out),
        .sel_n_in(sel_n_in), .ser_out(ser_out), .ser_in(ser_in)
    );

    function automatic logic [15:0] mk(input logic lp, input logic ih, input logic er,
                                       input logic d16, input logic msb, input logic mst,
                                       input logic en, input logic [3:0] len,
                                       input logic [3:0] pm);
        return {1'b0, lp, ih, er, d16, msb, mst, en, len, pm};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // monitor: pops the scoreboard on every receive pulse (R2 R7 R10 R11)
    always @(negedge clk) begin
        if (!rst && rx_valid) begin
            if (exp_q.size() == 0)
                check("R11 unexpected rx pulse", 32'(rx_word), 32'hDEAD);
            else
                check("R2/R7/R10 rx character", 32'(rx_word), 32'(exp_q.pop_front()));
        end
    end

    task automatic set_mode(input logic [15:0] m);
        @(negedge clk);
        mode_we = 1'b1;
        mode_wdata = m;
        @(negedge clk);
        mode_we = 1'b0;
    endtask

    // returns at the first negedge after the accepting edge
    task automatic master_start(input logic [15:0] w, input logic [15:0] expect_rx, input logic push);
        if (push)
            exp_q.push_back(expect_rx);
        @(negedge clk);
        tx_word = w;
        tx_valid = 1'b1;
        while (!tx_ready) @(negedge clk);
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (sel_n_out == 1'b0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic half_period(output int n);
        logic prev;
        prev = sck_out;
        while (sck_out == prev) @(negedge clk);
        prev = sck_out;
        n = 0;
        while (sck_out == prev) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic grab(input logic msb, output logic [7:0] got);
        logic prev;
        got = '0;
        prev = sck_out;
        for (int i = 0; i < 8; i++) begin
            logic seen;
            seen = 1'b0;
            while (!seen) begin
                @(negedge clk);
                seen = sck_out && !prev;
                prev = sck_out;
            end
            got = msb ? {got[6:0], ser_out} : {ser_out, got[7:1]};
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int hp;
        int lat;
        logic [7:0] got;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // reset state
        check("R1 reset mode", 32'(mode_rdata), 32'h0);
        check("R3 reset sck idle", 32'(sck_out), 32'h0);
        check("R11 reset tx_ready", 32'(tx_ready), 32'h0);
        check("R11 reset sel_n_out", 32'(sel_n_out), 32'h1);

        // R1 reserved bit
        set_mode(16'hFFFF);
        check("R1 reserved bit clear", 32'(mode_rdata), 32'h7FFF);
        set_mode(16'h0000);

        // R3 idle high level
        set_mode(mk(0, 1, 0, 0, 1, 1, 1, 4'd7, 4'd0));
        @(negedge clk);
        check("R3 idle high", 32'(sck_out), 32'h1);
        check("R11 master idle ready", 32'(tx_ready), 32'h1);

        // R2 loopback, ser_in ignored
        set_mode(mk(1, 0, 0, 0, 1, 1, 1, 4'd7, 4'd0));
        ser_in = 1'b1;
        master_start(16'h00A5, 16'h00A5, 1'b1);
        wait_idle();
        ser_in = 1'b0;
        master_start(16'h003C, 16'h003C, 1'b1);
        wait_idle();
        set_mode(mk(1, 0, 0, 0, 0, 1, 1, 4'd7, 4'd0));
        master_start(16'h000B, 16'h000B, 1'b1);
        wait_idle();

        // R7 length clamping and full width
        set_mode(mk(1, 0, 0, 0, 1, 1, 1, 4'd2, 4'd0));
        master_start(16'hFFFA, 16'h000A, 1'b1);
        wait_idle();
        set_mode(mk(1, 0, 0, 0, 1, 1, 1, 4'd15, 4'd0));
        master_start(16'hBEEF, 16'hBEEF, 1'b1);
        wait_idle();

        // R5 clock phase start latency
        set_mode(mk(1, 0, 1, 0, 1, 1, 1, 4'd7, 4'd0));
        master_start(16'h0081, 16'h0081, 1'b1);
        lat = 1;
        while (sck_out == 1'b0) begin @(negedge clk); lat++; end
        check("R5 early phase first edge", 32'(lat), 32'd1);
        wait_idle();
        set_mode(mk(1, 0, 0, 0, 1, 1, 1, 4'd7, 4'd0));
        master_start(16'h0042, 16'h0042, 1'b1);
        lat = 1;
        while (sck_out == 1'b0) begin @(negedge clk); lat++; end
        check("R5 late phase first edge", 32'(lat), 32'd3);
        wait_idle();

        // R4 half period, direct and divided
        ser_in = 1'b1;
        set_mode(mk(0, 0, 0, 0, 1, 1, 1, 4'd7, 4'd2));
        master_start(16'h0000, 16'h00FF, 1'b1);
        half_period(hp);
        check("R4 half period PM=2", 32'(hp), 32'd6);
        wait_idle();
        set_mode(mk(0, 0, 0, 1, 1, 1, 1, 4'd7, 4'd0));
        master_start(16'h0000, 16'h00FF, 1'b1);
        half_period(hp);
        check("R4 half period div16", 32'(hp), 32'd32);
        wait_idle();

        // R6 bit order on ser_out
        set_mode(mk(0, 0, 0, 0, 1, 1, 1, 4'd7, 4'd0));
        master_start(16'h00C5, 16'h00FF, 1'b1);
        grab(1'b1, got);
        check("R6 msb first order", 32'(got), 32'hC5);
        wait_idle();
        set_mode(mk(0, 0, 0, 0, 0, 1, 1, 4'd7, 4'd0));
        master_start(16'h00C5, 16'h00FF, 1'b1);
        grab(1'b0, got);
        check("R6 lsb first order", 32'(got), 32'hC5);
        wait_idle();

        // R8 deferred mode write
        set_mode(mk(0, 0, 0, 0, 1, 1, 1, 4'd7, 4'd2));
        master_start(16'h0000, 16'h00FF, 1'b1);
        set_mode(mk(0, 0, 0, 0, 1, 1, 1, 4'd7, 4'd0));
        half_period(hp);
        check("R8 old timing kept", 32'(hp), 32'd6);
        wait_idle();
        master_start(16'h0000, 16'h00FF, 1'b1);
        half_period(hp);
        check("R8 new timing applied", 32'(hp), 32'd2);
        wait_idle();

        // R9 abort on disable
        set_mode(mk(0, 1, 0, 0, 1, 1, 1, 4'd15, 4'd3));
        master_start(16'h1234, 16'h0000, 1'b0);
        repeat (12) @(negedge clk);
        set_mode(mk(0, 1, 0, 0, 1, 1, 0, 4'd15, 4'd3));
        @(negedge clk);
        check("R9 sck idle after abort", 32'(sck_out), 32'h1);
        check("R9 select released", 32'(sel_n_out), 32'h1);
        repeat (200) @(negedge clk);
        check("R9 sck stays idle", 32'(sck_out), 32'h1);

        // R10 slave transfer, R11 ready gating
        set_mode(mk(0, 0, 0, 0, 1, 0, 1, 4'd7, 4'd0));
        repeat (4) @(negedge clk);
        check("R11 slave not ready without select", 32'(tx_ready), 32'h0);
        tx_word = 16'h0096;
        tx_valid = 1'b1;
        sel_n_in = 1'b0;
        exp_q.push_back(16'h005A);
        while (!tx_ready) @(negedge clk);
        @(negedge clk);
        tx_valid = 1'b0;
        got = '0;
        for (int i = 7; i >= 0; i--) begin
            ser_in = 8'h5A >> i;
            repeat (16) @(negedge clk);
            got = {got[6:0], ser_out};
            sck_in = 1'b1;
            repeat (16) @(negedge clk);
            sck_in = 1'b0;
        end
        repeat (16) @(negedge clk);
        sel_n_in = 1'b1;
        check("R10 slave ser_out character", 32'(got), 32'h96);
        repeat (20) @(negedge clk);

        check("R11 scoreboard drained", 32'(exp_q.size()), 32'd0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule